// File: doc/BRIEF.md
# Register-Controlled Pad Routing Crossbar

This block sits between a set of external pads and the internal serial and general-purpose signals of a chip. A byte-wide register bank, reached through a plain synchronous write/read port, decides what each pad drives and which pad feeds each internal receive-side input. The tristate buffers themselves live outside: the block hands out a data value and an enable for every pad and takes in the pad's sensed level.

Every pad owns one register. Its upper five bits pick a source from 32 codes, bit 2 reports the pad's synchronized level, bit 1 is a data bit for software-driven use and bit 0 enables the driver. Code 31 turns the pad into a software-driven pin. Code 0 freezes the output value and enable as they stood when it was written. Codes in between route another pad's input, an internal signal or one of four clock inputs. Sink registers use only a five-bit pad select. Three control registers arm a push-switch reset, force a reset and report the switch level. All registers load fixed defaults on reset. Control pins are plain level signals, so there is no back-pressure anywhere: a write lands on the next rising edge and the read data register refreshes on every edge.

Top module: `pin_xbar`

## Requirements
- R1: A pad register at address i (0 to N_PADS-1) holds select in bits 7:3, the read-only synchronized pad level in bit 2, the output data bit in bit 1 and the output enable in bit 0. The bit 2 value written is ignored.
- R2: After reset, the pad registers read 0xa1, 0x89, 0xf8, 0x80, 0x08, 0x81, 0xf8, 0x71 for pads 0 to 7. The sink registers at addresses 16 to 19 read 0x20, 0x30, 0xf8, 0x10. The control registers read zero.
- R3: For a select other than 0, pad_oe of a pad equals its register's bit 0 from the clock edge that writes it.
- R4: Select 31 makes pad_out equal to the register's bit 1.
- R5: Select s in 1..N_PADS drives the synchronized input of pad s-1. Select s in N_PADS+1..26 drives int_src[s-N_PADS-1]. Select s in 27..30 drives clk_src[s-27].
- R6: Writing select 0 captures the pad's current pad_out and pad_oe. Both then stay constant while the select remains 0.
- R7: Read data is registered and appears one clock after addr. A pad's bit 2 follows pad_in through a two-flop synchronizer.
- R8: A sink register holds a pad select in bits 7:3, and bits 2:0 read zero. The sink output is the synchronized level of pad s-1 for s in 1..N_PADS, zero for select 31 and other unmapped codes, and holds its last value for select 0.
- R9: Bit 1 at address 29 arms the switch reset: hw_reset_o is high while armed and the synchronized sw_n_i is low.
- R10: Bit 1 at address 30 forces hw_reset_o high from the next edge. Bit 2 at address 31 reads back the synchronized switch level.
- R11: Addresses outside the map read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's addr |
| pad_in | input | N_PADS | Sensed pad levels (asynchronous) |
| pad_out | output | N_PADS | Value each pad drives |
| pad_oe | output | N_PADS | Driver enable for each pad |
| int_src | input | 26-N_PADS | Internal transmit-side signals |
| clk_src | input | 4 | Clock inputs selectable onto pads |
| sink_o | output | N_SINKS | Internal receive-side inputs chosen from pads |
| sw_n_i | input | 1 | Push switch, active low |
| hw_reset_o | output | 1 | Hardware reset request |

## Verification
Some properties are checked on every cycle. A write with a non-freeze select sets the enable on the next edge. A frozen pad stays still. Select 31 drives the data bit. Unmapped sink codes stay low. Unmapped addresses and reserved sink bits read zero. A force write raises the reset output. Other behaviour can only be shown by the bench's scenarios: the full reset image, every select code on one pad, pad-to-pad and clock routing under random inputs, the freeze capture, the synchronizer delay on readback and sinks, and the armed switch reset.

// File: rtl/pin_xbar_pkg.sv
`timescale 1ns/1ps
package pin_xbar_pkg;
  localparam int SEL_W      = 5;
  localparam int N_CLK      = 4;
  localparam int ROUTE_LAST = 26;
  localparam int CLK_FIRST  = 27;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_HOLD = 5'd0;
  localparam sel_t SEL_GPIO = 5'd31;
endpackage

// File: rtl/pin_xbar_sync.sv
`timescale 1ns/1ps
module pin_xbar_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      q_o    <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pin_xbar_pad_lane.sv
`timescale 1ns/1ps
module pin_xbar_pad_lane
  import pin_xbar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  sel_t        sel_i,
  input  logic        dq_i,
  input  logic        oe_i,
  input  logic [31:0] src_i,
  input  logic        cap_i,
  output logic        out_o,
  output logic        oe_o
);
  logic hold_out_q, hold_oe_q;

  always_comb begin
    if (sel_i == SEL_HOLD) begin
      out_o = hold_out_q;
      oe_o  = hold_oe_q;
    end else begin
      oe_o  = oe_i;
      out_o = (sel_i == SEL_GPIO) ? dq_i : src_i[sel_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_out_q <= 1'b0;
      hold_oe_q  <= 1'b0;
    end else if (cap_i) begin
      hold_out_q <= out_o;
      hold_oe_q  <= oe_o;
    end
  end

  assert_frozen_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_HOLD && $past(sel_i) == SEL_HOLD) |-> ($stable(out_o) && $stable(oe_o)));

  assert_gpio_drives_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_GPIO) |-> (out_o == dq_i));
endmodule

// File: rtl/pin_xbar_sink_lane.sv
`timescale 1ns/1ps
module pin_xbar_sink_lane
  import pin_xbar_pkg::*;
#(
  parameter int N_PADS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_t              sel_i,
  input  logic [N_PADS-1:0] pads_i,
  output logic              sink_o
);
  logic hold_q;

  always_comb begin
    sink_o = 1'b0;
    if (sel_i == SEL_HOLD) sink_o = hold_q;
    for (int k = 0; k < N_PADS; k++)
      if (sel_i == SEL_W'(k + 1)) sink_o = pads_i[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_q <= 1'b0;
    else if (sel_i != SEL_HOLD) hold_q <= sink_o;
  end

  assert_sink_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_i) > N_PADS) |-> !sink_o);
endmodule

// File: rtl/pin_xbar.sv
`timescale 1ns/1ps
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int                    N_PADS    = 8,
  parameter int                    N_SINKS   = 4,
  parameter int                    SINK_BASE = 16,
  parameter int                    CTL_BASE  = 29,
  parameter logic [N_PADS*8-1:0]   PAD_RST   = 64'h71f8_8108_80f8_89a1,
  parameter logic [N_SINKS*8-1:0]  SINK_RST  = 32'h10f8_3020,
  localparam int                   N_INT     = ROUTE_LAST - N_PADS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [N_PADS-1:0]  pad_in,
  output logic [N_PADS-1:0]  pad_out,
  output logic [N_PADS-1:0]  pad_oe,
  input  logic [N_INT-1:0]   int_src,
  input  logic [N_CLK-1:0]   clk_src,
  output logic [N_SINKS-1:0] sink_o,
  input  logic               sw_n_i,
  output logic               hw_reset_o
);
  sel_t              pad_sel  [N_PADS];
  logic [N_PADS-1:0] pad_dq, pad_en;
  sel_t              sink_sel [N_SINKS];
  logic              ctl_arm, ctl_force;
  logic [N_PADS-1:0] pad_s;
  logic              sw_s;
  logic [31:0]       src_all;
  logic [7:0]        rd_d;
  logic              addr_hit;

  pin_xbar_sync #(.W(N_PADS), .RST_VAL(1'b0)) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(pad_s));
  pin_xbar_sync #(.W(1), .RST_VAL(1'b1)) u_sw_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sw_n_i), .q_o(sw_s));

  // register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PADS; i++) begin
        pad_sel[i] <= PAD_RST[i*8+3 +: SEL_W];
        pad_dq[i]  <= PAD_RST[i*8+1];
        pad_en[i]  <= PAD_RST[i*8];
      end
      for (int j = 0; j < N_SINKS; j++) sink_sel[j] <= SINK_RST[j*8+3 +: SEL_W];
      ctl_arm   <= 1'b0;
      ctl_force <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < N_PADS; i++)
        if (addr == 8'(i)) begin
          pad_sel[i] <= wdata[7:3];
          pad_dq[i]  <= wdata[1];
          pad_en[i]  <= wdata[0];
        end
      for (int j = 0; j < N_SINKS; j++)
        if (addr == 8'(SINK_BASE + j)) sink_sel[j] <= wdata[7:3];
      if (addr == 8'(CTL_BASE))     ctl_arm   <= wdata[1];
      if (addr == 8'(CTL_BASE + 1)) ctl_force <= wdata[1];
    end
  end

  // shared source vector: pads, internal signals, clocks
  always_comb begin
    src_all = '0;
    for (int k = 0; k < N_PADS; k++) src_all[k + 1] = pad_s[k];
    for (int k = 0; k < N_INT; k++)  src_all[N_PADS + 1 + k] = int_src[k];
    for (int k = 0; k < N_CLK; k++)  src_all[CLK_FIRST + k] = clk_src[k];
  end

  for (genvar gi = 0; gi < N_PADS; gi++) begin : g_pad
    logic cap;
    assign cap = wr_en && (addr == 8'(gi)) && (wdata[7:3] == SEL_HOLD);
    pin_xbar_pad_lane u_lane (
      .clk(clk), .rst_n(rst_n), .sel_i(pad_sel[gi]), .dq_i(pad_dq[gi]),
      .oe_i(pad_en[gi]), .src_i(src_all), .cap_i(cap),
      .out_o(pad_out[gi]), .oe_o(pad_oe[gi]));

    assert_oe_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'(gi) && wdata[7:3] != SEL_HOLD) |=> (pad_oe[gi] == $past(wdata[0])));
  end

  for (genvar gj = 0; gj < N_SINKS; gj++) begin : g_sink
    pin_xbar_sink_lane #(.N_PADS(N_PADS)) u_lane (
      .clk(clk), .rst_n(rst_n), .sel_i(sink_sel[gj]), .pads_i(pad_s),
      .sink_o(sink_o[gj]));
  end

  assign hw_reset_o = ctl_force | (ctl_arm & ~sw_s);

  // readback
  always_comb begin
    rd_d     = '0;
    addr_hit = 1'b0;
    for (int i = 0; i < N_PADS; i++)
      if (addr == 8'(i)) begin
        rd_d     = {pad_sel[i], pad_s[i], pad_dq[i], pad_en[i]};
        addr_hit = 1'b1;
      end
    for (int j = 0; j < N_SINKS; j++)
      if (addr == 8'(SINK_BASE + j)) begin
        rd_d     = {sink_sel[j], 3'b000};
        addr_hit = 1'b1;
      end
    if (addr == 8'(CTL_BASE))     begin rd_d = {6'd0, ctl_arm, 1'b0};   addr_hit = 1'b1; end
    if (addr == 8'(CTL_BASE + 1)) begin rd_d = {6'd0, ctl_force, 1'b0}; addr_hit = 1'b1; end
    if (addr == 8'(CTL_BASE + 2)) begin rd_d = {5'd0, sw_s, 2'b00};     addr_hit = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (rdata == 8'd0));

  assert_sink_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 8'(SINK_BASE) && addr < 8'(SINK_BASE + N_SINKS)) |=> (rdata[2:0] == 3'd0));

  assert_force_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'(CTL_BASE + 1) && wdata[1]) |=> hw_reset_o);
endmodule

// File: tb/sim_pin_xbar.sv
`timescale 1ns/1ps
module sim_pin_xbar;
  localparam int NP = 8;
  localparam int NS = 4;
  localparam int NI = 26 - NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NI-1:0] int_src = '0;
  logic [3:0]    clk_src = '0;
  logic [NS-1:0] sink_o;
  logic          sw_n_i = 1'b1;
  logic          hw_reset_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pin_xbar u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .int_src(int_src), .clk_src(clk_src), .sink_o(sink_o),
    .sw_n_i(sw_n_i), .hw_reset_o(hw_reset_o));

  // bench model of the register contents
  logic [7:0] rst_pad  [NP] = '{8'ha1, 8'h89, 8'hf8, 8'h80, 8'h08, 8'h81, 8'hf8, 8'h71};
  logic [7:0] rst_sink [NS] = '{8'h20, 8'h30, 8'hf8, 8'h10};
  logic [4:0] m_sel [NP];
  logic       m_dq  [NP];
  logic       m_oe  [NP];
  logic [1:0] m_hold[NP];
  logic [4:0] m_ssel [NS];
  logic       m_shold[NS];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pad(int i);
    logic o, e;
    if (m_sel[i] == 5'd0) return m_hold[i];
    e = m_oe[i];
    if (m_sel[i] == 5'd31)                         o = m_dq[i];
    else if (m_sel[i] >= 1 && m_sel[i] <= NP)      o = pad_in[m_sel[i] - 1];
    else if (m_sel[i] <= 26)                       o = int_src[m_sel[i] - NP - 1];
    else                                           o = clk_src[m_sel[i] - 27];
    return {o, e};
  endfunction

  function automatic logic exp_sink(int j);
    if (m_ssel[j] == 5'd0) return m_shold[j];
    if (m_ssel[j] >= 1 && m_ssel[j] <= NP) return pad_in[m_ssel[j] - 1];
    return 1'b0;
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a < NP) begin
      if (d[7:3] == 5'd0) m_hold[a] = exp_pad(a);
      m_sel[a] = d[7:3]; m_dq[a] = d[1]; m_oe[a] = d[0];
    end else if (a >= 16 && a < 16 + NS) begin
      if (d[7:3] == 5'd0) m_shold[a - 16] = exp_sink(a - 16);
      m_ssel[a - 16] = d[7:3];
    end
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    #1 v = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic check_all_outputs(string req);
    for (int i = 0; i < NP; i++) begin
      logic [1:0] e;
      e = exp_pad(i);
      chk(req, $sformatf("pad%0d out", i), 32'(pad_out[i]), 32'(e[1]));
      chk(req, $sformatf("pad%0d oe", i), 32'(pad_oe[i]), 32'(e[0]));
    end
    for (int j = 0; j < NS; j++)
      chk("R8", $sformatf("sink%0d", j), 32'(sink_o[j]), 32'(exp_sink(j)));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) begin
      m_sel[i] = rst_pad[i][7:3]; m_dq[i] = rst_pad[i][1]; m_oe[i] = rst_pad[i][0];
      m_hold[i] = 2'b00;
    end
    for (int j = 0; j < NS; j++) begin m_ssel[j] = rst_sink[j][7:3]; m_shold[j] = 1'b0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R2: reset image
    for (int i = 0; i < NP; i++) begin
      rd(8'(i), v); chk("R2", $sformatf("pad reg %0d", i), 32'(v), 32'(rst_pad[i]));
    end
    for (int j = 0; j < NS; j++) begin
      rd(8'(16 + j), v); chk("R2", $sformatf("sink reg %0d", j), 32'(v), 32'(rst_sink[j]));
    end
    rd(8'd29, v); chk("R2", "arm reg", 32'(v), 32'd0);
    rd(8'd30, v); chk("R2", "force reg", 32'(v), 32'd0);
    chk("R2", "hw_reset", 32'(hw_reset_o), 32'd0);
    check_all_outputs("R2");

    // R5: every select code on pad 2
    pad_in = 8'b1010_0110; int_src = 18'h2b5c3; clk_src = 4'b0101;
    settle();
    for (int c = 1; c < 32; c++) begin
      logic [7:0] d;
      d = {5'(c), 1'b0, 1'($urandom), 1'($urandom)};
      wr(8'd2, d);
      check_all_outputs(c == 31 ? "R4" : "R5");
    end
    // R6: freeze captures current drive
    wr(8'd2, {5'd31, 3'b011});
    wr(8'd2, 8'h00);
    chk("R6", "frozen out", 32'(pad_out[2]), 32'd1);
    chk("R6", "frozen oe", 32'(pad_oe[2]), 32'd1);
    pad_in = ~pad_in; settle();
    wr(8'd2, 8'h00);
    check_all_outputs("R6");
    rd(8'd2, v); chk("R7", "frozen reg readback", 32'(v), 32'({5'd0, pad_in[2], 2'b00}));

    // R1/R7: bit 2 is the synchronized input, writes to it ignored
    wr(8'd4, 8'hff);
    pad_in[4] = 1'b0;
    settle();
    rd(8'd4, v); chk("R1", "bit2 ignores write", 32'(v), 32'h0000_00fb);
    pad_in[4] = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    addr = 8'd4;
    @(negedge clk); #1;
    chk("R7", "readback after 2 sync + 1 read edge", 32'(rdata[2]), 32'd1);

    // R8 sink directed
    wr(8'd17, 8'hff); rd(8'd17, v); chk("R8", "sink reserved bits", 32'(v), 32'h0000_00f8);
    wr(8'd17, {5'd3, 3'b000});
    chk("R8", "sink picks pad2", 32'(sink_o[1]), 32'(pad_in[2]));
    wr(8'd17, 8'h00);
    pad_in[2] = ~pad_in[2]; settle();
    chk("R8", "sink held", 32'(sink_o[1]), 32'(m_shold[1]));

    // R11: unmapped address
    wr(8'd24, 8'hff); rd(8'd24, v); chk("R11", "unmapped read", 32'(v), 32'd0);
    check_all_outputs("R11");

    // R9/R10: reset control
    wr(8'd29, 8'h02);
    chk("R9", "armed switch high", 32'(hw_reset_o), 32'd0);
    sw_n_i = 1'b0; settle();
    chk("R9", "armed switch low", 32'(hw_reset_o), 32'd1);
    rd(8'd31, v); chk("R10", "switch level low", 32'(v), 32'd0);
    sw_n_i = 1'b1; settle();
    chk("R9", "switch released", 32'(hw_reset_o), 32'd0);
    rd(8'd31, v); chk("R10", "switch level high", 32'(v), 32'h0000_0004);
    wr(8'd29, 8'h00);
    sw_n_i = 1'b0; settle();
    chk("R9", "disarmed", 32'(hw_reset_o), 32'd0);
    sw_n_i = 1'b1;
    wr(8'd30, 8'h02);
    chk("R10", "force", 32'(hw_reset_o), 32'd1);
    wr(8'd30, 8'h00);
    chk("R10", "force cleared", 32'(hw_reset_o), 32'd0);

    // random routing (R3, R5, R6, R8)
    for (int it = 0; it < 300; it++) begin
      pad_in  = NP'($urandom);
      int_src = NI'($urandom);
      clk_src = 4'($urandom);
      settle();
      if ($urandom_range(0, 3) == 0)
        wr(8'(16 + $urandom_range(0, NS - 1)), {5'($urandom_range(0, 31)), 3'($urandom)});
      else
        wr(8'($urandom_range(0, NP - 1)), 8'($urandom));
      check_all_outputs("R3");
      begin
        int a;
        a = $urandom_range(0, NP - 1);
        rd(8'(a), v);
        chk("R1", $sformatf("pad reg %0d", a), 32'(v),
            32'({m_sel[a], pad_in[a], m_dq[a], m_oe[a]}));
      end
    end

    report();
  end
endmodule